// File: doc/BRIEF.md
# Floating-Point Control Word with Dynamic Accuracy Tier

This block keeps the control and status word of a floating-point unit. The word holds sticky exception flags, a dynamic rounding mode and a dynamic accuracy tier. The tier names the least accuracy a result may have. The format of operands and results never depends on the tier, and an answer more exact than the tier asks for is always acceptable. Software reaches the word through a CSR-style port that can read, write, set bits or clear bits. The port offers two views: the full 32-bit word, and the rounding mode alone, right-aligned. The arithmetic datapath ORs its exception flags into the word each time an operation completes.

For every floating-point instruction at issue, the block resolves the rounding mode the instruction will use. It reports the active accuracy tier and raises illegal-instruction in the same cycle when the instruction cannot run as asked. That happens for two reasons. The instruction may request the dynamic rounding mode while the stored mode is invalid. Or the operation class may not be supported under the current tier, in which case trap software is expected to emulate it. An elaboration-time mask parameter fixes which tier and class pairs are supported.

Top module: `fpctl_acc_top`

## Requirements
- R1: After reset the stored word is zero, so the accuracy tier is 000 (correctly rounded IEEE754), the rounding mode is 000 and no flag is set.
- R2: Word bits 31..11 always read as zero, and no CSR write, set or clear changes them.
- R3: With csr_view=0 and csr_en=1, csr_op 01 replaces bits 10..0 with csr_wdata[10..0], 10 ORs csr_wdata[10..0] into them and 11 clears the bits that are one in csr_wdata[10..0]. csr_op 00 only reads. The layout is flags in bits 4..0, rounding mode in bits 7..5 and accuracy tier in bits 10..8.
- R4: With csr_view=1, csr_rdata is the rounding mode in bits 2..0 with zeros above it, and write, set or clear apply csr_wdata[2..0] to the rounding mode only. Flags and tier are unchanged.
- R5: When fp_done is high, fp_flags is ORed into the flag field at the clock edge. The flags stay set until software clears them.
- R6: When a CSR write and fp_done occur in the same cycle, the CSR result is applied first and fp_flags is then ORed into the flag field of that result.
- R7: An iss_rm of 111 makes eff_rm the stored rounding mode, and any other iss_rm value is passed to eff_rm unchanged.
- R8: If iss_valid is high, iss_rm is 111 and the stored rounding mode is 101, 110 or 111, then iss_illegal is high.
- R9: eff_acc is the stored tier. The tier codes are 000 IEEE754, 010 below one ULP, 100 GPU few-ULP and 110 fast approximate. Under a tier code, class c is supported when bit (code/2)*NUM_CLASS+c of SUPPORT_MASK is set. The default mask 16'h3F7F supports classes 0..3 under 000 and 100, classes 0..2 under 010, and classes 0..1 under 110. An issued class that is not supported raises iss_illegal.
- R10: A tier code with bit 0 set is stored and read back unchanged, and any valid issue under it raises iss_illegal whatever the class.
- R11: iss_illegal, eff_rm and eff_acc depend only on the stored word and the issue inputs, in the same cycle. iss_illegal is low whenever iss_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access strobe |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_view | input | 1 | 0 full word, 1 rounding mode alone |
| csr_wdata | input | 32 | CSR write operand |
| csr_rdata | output | 32 | Current value of the selected view |
| fp_done | input | 1 | Datapath operation completed |
| fp_flags | input | 5 | Exception flags raised by that operation |
| iss_valid | input | 1 | A floating-point instruction is at issue |
| iss_rm | input | 3 | Rounding field of the instruction |
| iss_cls | input | CLS_W | Operation class of the instruction |
| eff_rm | output | 3 | Resolved rounding mode |
| eff_acc | output | 3 | Active accuracy tier |
| iss_illegal | output | 1 | Instruction must trap |

## Verification
The bench targets a CSR write that arrives together with a datapath completion. A design that lets the write win would lose the new flags, and one that lets the flags win would drop the write. It writes the rounding-mode view with the upper bits of the write data set, so a design that leaks those bits into the flags or the tier is caught. It steps through every tier code, including the undefined odd ones, against every class. A design with a wrong mask index or with undefined codes treated as IEEE754 would miss traps or raise spurious ones. It also issues static rounding fields while the stored mode is invalid, and holds iss_valid low in a state that would trap, so that a design trapping too often shows up.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

   localparam int WORD_W   = 32;
   localparam int FLAG_W   = 5;
   localparam int RM_W     = 3;
   localparam int ACC_W    = 3;
   localparam int FLAG_LSB = 0;
   localparam int RM_LSB   = FLAG_LSB + FLAG_W;
   localparam int ACC_LSB  = RM_LSB + RM_W;
   localparam int LIVE_W   = ACC_LSB + ACC_W;
   localparam int NUM_TIERS = 4;

   typedef enum logic [1:0] {
      CSR_READ  = 2'b00,
      CSR_WRITE = 2'b01,
      CSR_SET   = 2'b10,
      CSR_CLEAR = 2'b11
   } csr_op_e;

   localparam logic [RM_W-1:0] RM_DYNAMIC   = 3'b111;
   localparam logic [RM_W-1:0] RM_FIRST_BAD = 3'b101;

   function automatic logic [ACC_W-1:0] tier_code(input int t);
      return ACC_W'(t * 2);
   endfunction

endpackage

// File: rtl/fpctl_csr_update.sv
module fpctl_csr_update
   import fpctl_pkg::*;
(
   input  logic [LIVE_W-1:0] cur_word,
   input  logic              csr_en,
   input  logic [1:0]        csr_op,
   input  logic              csr_view,
   input  logic [LIVE_W-1:0] wr_live,
   output logic [LIVE_W-1:0] nxt_word,
   output logic [WORD_W-1:0] rd_word
);

   localparam logic [LIVE_W-1:0] RM_FIELD   = LIVE_W'({RM_W{1'b1}}) << RM_LSB;
   localparam logic [LIVE_W-1:0] LIVE_FIELD = {LIVE_W{1'b1}};

   logic [LIVE_W-1:0] aff_mask;
   logic [LIVE_W-1:0] operand;
   logic [LIVE_W-1:0] hit;
   csr_op_e           op;

   assign op       = csr_op_e'(csr_op);
   assign aff_mask = csr_view ? RM_FIELD : LIVE_FIELD;
   assign operand  = csr_view ? (LIVE_W'(wr_live[RM_W-1:0]) << RM_LSB) : wr_live;
   assign hit      = operand & aff_mask;

   always_comb begin
      nxt_word = cur_word;
      if (csr_en) begin
         unique case (op)
            CSR_WRITE: nxt_word = (cur_word & ~aff_mask) | hit;
            CSR_SET:   nxt_word = cur_word | hit;
            CSR_CLEAR: nxt_word = cur_word & ~hit;
            default:   nxt_word = cur_word;
         endcase
      end
   end

   always_comb begin
      if (csr_view)
         rd_word = WORD_W'(cur_word[RM_LSB +: RM_W]);
      else
         rd_word = WORD_W'(cur_word);
   end

endmodule

// File: rtl/fpctl_word_reg.sv
module fpctl_word_reg
   import fpctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIVE_W-1:0] nxt_word,
   input  logic              fp_done,
   input  logic [FLAG_W-1:0] fp_flags,
   output logic [LIVE_W-1:0] cur_word
);

   logic [LIVE_W-1:0] flag_or;

   assign flag_or = fp_done ? (LIVE_W'(fp_flags) << FLAG_LSB) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_word <= '0;
      else
         cur_word <= nxt_word | flag_or;
   end

endmodule

// File: rtl/fpctl_issue_check.sv
module fpctl_issue_check
   import fpctl_pkg::*;
#(
   parameter int NUM_CLASS = 4,
   parameter int CLS_W     = 2,
   parameter logic [NUM_TIERS*NUM_CLASS-1:0] SUPPORT_MASK = '1
) (
   input  logic [RM_W-1:0]  stored_rm,
   input  logic [ACC_W-1:0] stored_acc,
   input  logic             iss_valid,
   input  logic [RM_W-1:0]  iss_rm,
   input  logic [CLS_W-1:0] iss_cls,
   output logic [RM_W-1:0]  eff_rm,
   output logic [ACC_W-1:0] eff_acc,
   output logic             iss_illegal
);

   logic [NUM_TIERS-1:0] tier_ok;
   logic                 cls_in_range;
   logic                 acc_ok;
   logic                 dyn_sel;
   logic                 rm_bad;

   assign cls_in_range = (32'(iss_cls) < NUM_CLASS);

   for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      logic [NUM_CLASS-1:0] row;
      assign row        = SUPPORT_MASK[t*NUM_CLASS +: NUM_CLASS];
      assign tier_ok[t] = (stored_acc == tier_code(t)) && cls_in_range && row[iss_cls];
   end

   assign acc_ok      = |tier_ok;
   assign dyn_sel     = (iss_rm == RM_DYNAMIC);
   assign rm_bad      = dyn_sel && (stored_rm >= RM_FIRST_BAD);
   assign eff_rm      = dyn_sel ? stored_rm : iss_rm;
   assign eff_acc     = stored_acc;
   assign iss_illegal = iss_valid && (rm_bad || !acc_ok);

endmodule

// File: rtl/fpctl_acc_top.sv
module fpctl_acc_top
   import fpctl_pkg::*;
#(
   parameter int NUM_CLASS = 4,
   parameter int CLS_W     = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1,
   parameter logic [NUM_TIERS*NUM_CLASS-1:0] SUPPORT_MASK = 16'h3F7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic [1:0]        csr_op,
   input  logic              csr_view,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              fp_done,
   input  logic [4:0]        fp_flags,
   input  logic              iss_valid,
   input  logic [2:0]        iss_rm,
   input  logic [CLS_W-1:0]  iss_cls,
   output logic [2:0]        eff_rm,
   output logic [2:0]        eff_acc,
   output logic              iss_illegal
);

   if (LIVE_W > WORD_W) begin : g_bad_layout
      $error("control word fields exceed the word width");
   end
   if (NUM_CLASS < 1) begin : g_bad_classes
      $error("NUM_CLASS must be at least one");
   end
   if ((1 << CLS_W) < NUM_CLASS) begin : g_bad_cls_w
      $error("CLS_W too narrow for NUM_CLASS");
   end

   logic [LIVE_W-1:0] cur_word;
   logic [LIVE_W-1:0] nxt_word;
   logic              resv_wr_unused;

   assign resv_wr_unused = ^csr_wdata[WORD_W-1:LIVE_W];

   fpctl_csr_update u_upd (
      .cur_word (cur_word),
      .csr_en   (csr_en),
      .csr_op   (csr_op),
      .csr_view (csr_view),
      .wr_live  (csr_wdata[LIVE_W-1:0]),
      .nxt_word (nxt_word),
      .rd_word  (csr_rdata)
   );

   fpctl_word_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_word (nxt_word),
      .fp_done  (fp_done),
      .fp_flags (fp_flags),
      .cur_word (cur_word)
   );

   fpctl_issue_check #(
      .NUM_CLASS    (NUM_CLASS),
      .CLS_W        (CLS_W),
      .SUPPORT_MASK (SUPPORT_MASK)
   ) u_iss (
      .stored_rm   (cur_word[RM_LSB +: RM_W]),
      .stored_acc  (cur_word[ACC_LSB +: ACC_W]),
      .iss_valid   (iss_valid),
      .iss_rm      (iss_rm),
      .iss_cls     (iss_cls),
      .eff_rm      (eff_rm),
      .eff_acc     (eff_acc),
      .iss_illegal (iss_illegal)
   );

endmodule

// File: rtl/fpctl_acc_chk.sv
module fpctl_acc_chk
   import fpctl_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              csr_en,
   input logic [1:0]        csr_op,
   input logic              csr_view,
   input logic [31:0]       csr_rdata,
   input logic              fp_done,
   input logic [4:0]        fp_flags,
   input logic              iss_valid,
   input logic [2:0]        iss_rm,
   input logic [2:0]        eff_rm,
   input logic              iss_illegal,
   input logic [LIVE_W-1:0] cur_word
);

   p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_view |-> (csr_rdata[31:LIVE_W] == '0));

   p_rm_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
      csr_view |-> (csr_rdata[31:RM_W] == '0));

   p_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(csr_en && csr_op == 2'b00 && !fp_done)) |-> $stable(cur_word));

   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!csr_en && fp_done))
         |-> ((cur_word[FLAG_W-1:0] & $past(fp_flags)) == $past(fp_flags)));

   p_flag_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(csr_en && fp_done))
         |-> ((cur_word[FLAG_W-1:0] & $past(fp_flags)) == $past(fp_flags)));

   p_static_rm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_rm != RM_DYNAMIC) |-> (eff_rm == iss_rm));

   p_dyn_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_rm == RM_DYNAMIC && cur_word[RM_LSB +: RM_W] >= RM_FIRST_BAD)
         |-> iss_illegal);

   p_odd_tier_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && cur_word[ACC_LSB]) |-> iss_illegal);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |-> !iss_illegal);

endmodule

bind fpctl_acc_top fpctl_acc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_en      (csr_en),
   .csr_op      (csr_op),
   .csr_view    (csr_view),
   .csr_rdata   (csr_rdata),
   .fp_done     (fp_done),
   .fp_flags    (fp_flags),
   .iss_valid   (iss_valid),
   .iss_rm      (iss_rm),
   .eff_rm      (eff_rm),
   .iss_illegal (iss_illegal),
   .cur_word    (cur_word)
);

// File: tb/tb_fpctl_acc_top.sv
module tb_fpctl_acc_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCLS = 4;
   localparam logic [15:0] MASK = 16'h3F7F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_en = 1'b0;
   logic [1:0]  csr_op = 2'b00;
   logic        csr_view = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        fp_done = 1'b0;
   logic [4:0]  fp_flags = '0;
   logic        iss_valid = 1'b0;
   logic [2:0]  iss_rm = '0;
   logic [1:0]  iss_cls = '0;
   logic [2:0]  eff_rm;
   logic [2:0]  eff_acc;
   logic        iss_illegal;

   int n_chk = 0;
   int n_bad = 0;
   logic [10:0] m_word = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpctl_acc_top dut (
      .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
      .csr_view(csr_view), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .fp_done(fp_done), .fp_flags(fp_flags), .iss_valid(iss_valid),
      .iss_rm(iss_rm), .iss_cls(iss_cls), .eff_rm(eff_rm),
      .eff_acc(eff_acc), .iss_illegal(iss_illegal)
   );

   function automatic logic [10:0] f_next(logic [10:0] w, logic en, logic [1:0] op,
                                          logic view, logic [31:0] wd,
                                          logic done, logic [4:0] fl);
      logic [10:0] aff = view ? 11'h0E0 : 11'h7FF;
      logic [10:0] opnd = view ? {3'b000, wd[2:0], 5'b00000} : wd[10:0];
      logic [10:0] n = w;
      if (en) begin
         case (op)
            2'b01: n = (w & ~aff) | (opnd & aff);
            2'b10: n = w | (opnd & aff);
            2'b11: n = w & ~(opnd & aff);
            default: n = w;
         endcase
      end
      if (done) n[4:0] = n[4:0] | fl;
      return n;
   endfunction

   function automatic logic [31:0] f_rdata(logic [10:0] w, logic view);
      return view ? {29'd0, w[7:5]} : {21'd0, w};
   endfunction

   function automatic logic [2:0] f_eff_rm(logic [10:0] w, logic [2:0] rm);
      return (rm == 3'b111) ? w[7:5] : rm;
   endfunction

   function automatic logic f_illegal(logic [10:0] w, logic v, logic [2:0] rm, logic [1:0] cls);
      logic dyn_bad = (rm == 3'b111) && (w[7:5] >= 3'b101);
      logic [2:0] acc = w[10:8];
      logic ok = (acc[0] == 1'b0) && MASK[int'(acc[2:1]) * NCLS + int'(cls)];
      if (!v) return 1'b0;
      return dyn_bad || !ok;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(string tag, logic en, logic [1:0] op, logic view, logic [31:0] wd,
                        logic done, logic [4:0] fl, logic v, logic [2:0] rm, logic [1:0] cls);
      csr_en = en; csr_op = op; csr_view = view; csr_wdata = wd;
      fp_done = done; fp_flags = fl; iss_valid = v; iss_rm = rm; iss_cls = cls;
      #(CLK_PERIOD/2 - 1);
      chk({tag, " rdata"}, csr_rdata, f_rdata(m_word, view));
      chk({tag, " eff_rm R7"}, 32'(eff_rm), 32'(f_eff_rm(m_word, rm)));
      chk({tag, " eff_acc R9"}, 32'(eff_acc), 32'(m_word[10:8]));
      chk({tag, " illegal R11"}, 32'(iss_illegal), 32'(f_illegal(m_word, v, rm, cls)));
      @(posedge clk);
      m_word = f_next(m_word, en, op, view, wd, done, fl);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset word
      drive("R1", 0, 2'b00, 0, 0, 0, 0, 1, 3'b111, 0);
      // R2: reserved bits ignore writes
      drive("R2", 1, 2'b01, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      drive("R2", 1, 2'b10, 0, 32'hFFFF_F800, 0, 0, 0, 0, 0);
      drive("R2", 1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
      // R3: write, clear, set on the full view
      drive("R3", 1, 2'b01, 0, 32'h0000_0000, 0, 0, 0, 0, 0);
      drive("R3", 1, 2'b10, 0, 32'h0000_0443, 0, 0, 0, 0, 0);
      drive("R3", 1, 2'b11, 0, 32'h0000_0002, 0, 0, 0, 0, 0);
      drive("R3", 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
      // R4: rounding view leaves other fields alone
      drive("R4", 1, 2'b01, 1, 32'hFFFF_FFFA, 0, 0, 0, 0, 0);
      drive("R4", 1, 2'b00, 1, 0, 0, 0, 0, 0, 0);
      drive("R4", 1, 2'b11, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
      drive("R4", 1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
      // R5: sticky flag accumulation
      drive("R5", 0, 2'b00, 0, 0, 1, 5'b10100, 0, 0, 0);
      drive("R5", 0, 2'b00, 0, 0, 1, 5'b00010, 0, 0, 0);
      drive("R5", 0, 2'b00, 0, 0, 0, 5'b11111, 0, 0, 0);
      // R6: write together with completion
      drive("R6", 1, 2'b01, 0, 32'h0000_0000, 1, 5'b00001, 0, 0, 0);
      drive("R6", 1, 2'b11, 0, 32'h0000_001F, 1, 5'b01000, 0, 0, 0);
      drive("R6", 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
      // R7 and R8: dynamic rounding resolution and invalid stored modes
      for (int m = 0; m < 8; m++) begin
         drive("R8", 1, 2'b01, 1, 32'(m), 0, 0, 1, 3'b111, 0);
         drive("R8", 0, 2'b00, 1, 0, 0, 0, 1, 3'b111, 0);
         drive("R7", 0, 2'b00, 1, 0, 0, 0, 1, 3'(m), 1);
      end
      drive("R7", 1, 2'b01, 1, 32'd2, 0, 0, 0, 0, 0);
      // R9 and R10: every tier code against every class
      for (int a = 0; a < 8; a++) begin
         drive("R9", 1, 2'b01, 0, 32'(a << 8) | 32'h040, 0, 0, 0, 0, 0);
         for (int c = 0; c < NCLS; c++)
            drive((a % 2 == 1) ? "R10" : "R9", 0, 2'b00, 0, 0, 0, 0, 1, 3'b000, 2'(c));
      end
      // R11: no trap without a valid issue in a trapping state
      drive("R11", 1, 2'b01, 0, 32'h0000_07E0, 0, 0, 0, 3'b111, 3);
      drive("R11", 0, 2'b00, 0, 0, 0, 0, 0, 3'b111, 3);
      drive("R11", 0, 2'b00, 0, 0, 0, 0, 1, 3'b111, 3);
      // Random mix covering R3 R4 R5 R6 R7 R8 R9 R10
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] wd = $urandom;
         logic [31:0] sel = $urandom;
         drive("RND R3 R4 R5 R6", sel[0] & sel[1], sel[3:2], sel[4], wd,
               sel[5], sel[10:6], sel[11], (sel[12] ? 3'b111 : sel[15:13]), sel[17:16]);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule